// File: doc/BRIEF.md
# Sequential LMS Adaptive Noise Canceller

This block removes correlated noise from a signal by adaptive filtering. It takes two sample streams. The desired input carries the wanted signal with noise added. The reference input carries the noise alone. A finite-impulse-response filter with adaptive coefficients estimates the noise component of the desired input from recent reference samples. The block subtracts that estimate, and the difference, called the error, is the cleaned output. The same error then adjusts every coefficient by the least-mean-squares rule, so the filter tracks the noise path over time.

All arithmetic is time-multiplexed through one signed multiplier and one adder, sequenced by a small state machine. Each iteration starts when a sample pair is accepted. It first accumulates the filter output one tap per cycle, then forms the saturated error and strobes it out, then updates the coefficients one tap per cycle. It then pads to a fixed iteration length. The state code and low nibbles of the multiplier and adder operands are brought out on debug pins so the sequencing can be observed on a tester.

Top module: `lms_canceller`

## Requirements
- R1: `rst_n` low asynchronously clears the block; it leaves reset two clock edges after `rst_n` rises. After reset `dbg_state` is 0, `err_out` is 0, `ready` is 0, and every coefficient and stored reference sample is zero, so the first result equals the desired sample.
- R2: A sample pair is accepted on a rising edge where `in_valid` is high and `dbg_state` is 0 (idle). The accepted reference sample enters tap 0 of the delay line, and every older sample moves one tap deeper.
- R3: While `dbg_state` is not 0, `in_valid`, `in_ref` and `in_desired` have no effect: the iteration in progress and all later results are unchanged.
- R4: Once accepted, an iteration lasts exactly ITER_CYCLES (default 175) clock edges before the block can accept again. With `in_valid` held high, successive `ready` pulses are exactly ITER_CYCLES cycles apart.
- R5: The error is sat8(d - floor(S / 2^14)). S is the sum over taps k of w[k]*x[k]. w[k] are 16-bit signed coefficients with 14 fraction bits, x[k] are the stored signed 8-bit reference samples, and d is the accepted desired sample.
- R6: `err_out` changes only together with a `ready` pulse. `ready` is high for exactly one cycle, which begins NTAPS+1 clock edges after the accepting edge.
- R7: After the error is formed, every coefficient k from 0 to NTAPS-1 is updated to sat16(w[k] + floor(e*x[k] / 2^MU_SHIFT)), with MU_SHIFT defaulting to 6. The result of the next iteration depends on these updated coefficients.
- R8: `dbg_state` shows the phase: 0 idle, 1 multiply-accumulate (filter output), 2 error formation, 3 coefficient update, 4 padding. `ready` is high only while the code is 3.
- R9: `dbg_mul_in` shows bits 3:0 of the reference-sample operand of the multiplier. `dbg_mul_out` shows bits 3:0 of the product. `dbg_add_in` shows bits 3:0 of the adder's second operand. In the cycle after acceptance these are x[3:0], (w[0]*x)[3:0] and (w[0]*x)[3:0].
- R10: When the desired input is a scaled, delayed copy of the reference, the error magnitude falls as the iterations proceed.
- R11: The error saturates: an unsaturated value below -128 gives -128, and one above 127 gives 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample pair offered; taken only when idle |
| in_ref | input | DW | Reference (noise-only) sample, signed |
| in_desired | input | DW | Desired (signal plus noise) sample, signed |
| err_out | output | DW | Cleaned output (saturated error), signed |
| ready | output | 1 | One-cycle strobe marking a new `err_out` |
| dbg_state | output | 4 | Current state code |
| dbg_mul_in | output | 4 | Low nibble of the multiplier's sample operand |
| dbg_mul_out | output | 4 | Low nibble of the product |
| dbg_add_in | output | 4 | Low nibble of the adder's second operand |

## Verification
The bound checker watches the sequencing on every cycle. It checks that acceptance happens only from idle and leads straight into accumulation, and that requests during padding do not restart the block. It checks that `ready` is a single pulse raised only in the update phase, that `err_out` holds between pulses, and that every iteration spans exactly ITER_CYCLES cycles. The arithmetic can only be shown by the bench scenarios, which compare every error against a bit-accurate model: the delay-line order, the coefficient updates and their carry-over between iterations, clipping at both rails, the debug nibbles, and the fall of the error as the filter converges on a delayed, halved copy of the reference.

// File: rtl/lms_pkg.sv
package lms_pkg;

  // State codes are visible on the debug pins; values are fixed.
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_MAC  = 4'd1,
    ST_ERR  = 4'd2,
    ST_UPD  = 4'd3,
    ST_HOLD = 4'd4
  } lms_state_e;

endpackage

// File: rtl/lms_rst_sync.sv
module lms_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lms_sample_stack.sv
module lms_sample_stack #(
  parameter int DW = 8,
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [DW-1:0] din,
  input  logic [IW-1:0]        rd_idx,
  output logic signed [DW-1:0] rd_data
);

  logic signed [DW-1:0] stage_q [N];
  logic signed [DW-1:0] stage_d [N];

  // Tap 0 takes the new sample, each deeper tap takes its neighbour.
  for (genvar g = 0; g < N; g++) begin : g_tap
    if (g == 0) begin : g_head
      assign stage_d[g] = din;
    end else begin : g_body
      assign stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) stage_q[k] <= '0;
    end else if (push) begin
      for (int k = 0; k < N; k++) stage_q[k] <= stage_d[k];
    end
  end

  assign rd_data = stage_q[rd_idx];

endmodule

// File: rtl/lms_weight_stack.sv
module lms_weight_stack #(
  parameter int WW = 16,
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        idx,
  input  logic signed [WW-1:0] wr_data,
  output logic signed [WW-1:0] rd_data
);

  logic signed [WW-1:0] coef_q [N];
  logic [N-1:0]         tap_en;

  for (genvar g = 0; g < N; g++) begin : g_en
    assign tap_en[g] = wr_en && (idx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) coef_q[k] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (tap_en[k]) coef_q[k] <= wr_data;
      end
    end
  end

  assign rd_data = coef_q[idx];

endmodule

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_pkg::*;
#(
  parameter int N           = 8,
  parameter int ITER_CYCLES = 175,
  parameter int IW          = 3,
  parameter int CW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output lms_state_e    state,
  output logic [IW-1:0] idx,
  output logic          push
);

  lms_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] cyc_q, cyc_d;

  localparam logic [IW-1:0] LAST_TAP = IW'(N - 1);
  localparam logic [CW-1:0] LAST_CYC = CW'(ITER_CYCLES - 1);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cyc_d   = cyc_q;
    push    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          push    = 1'b1;
          state_d = ST_MAC;
          idx_d   = '0;
          cyc_d   = CW'(1);
        end
      end
      ST_MAC: begin
        cyc_d = cyc_q + 1'b1;
        if (idx_q == LAST_TAP) begin
          state_d = ST_ERR;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_ERR: begin
        cyc_d   = cyc_q + 1'b1;
        state_d = ST_UPD;
        idx_d   = '0;
      end
      ST_UPD: begin
        cyc_d = cyc_q + 1'b1;
        if (idx_q == LAST_TAP) begin
          state_d = ST_HOLD;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cyc_q == LAST_CYC) begin
          state_d = ST_IDLE;
          cyc_d   = '0;
        end else begin
          cyc_d = cyc_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        idx_d   = '0;
        cyc_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cyc_q   <= cyc_d;
    end
  end

  assign state = state_q;
  assign idx   = idx_q;

endmodule

// File: rtl/lms_canceller.sv
module lms_canceller
  import lms_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NTAPS       = 8,
  parameter int WW          = 16,
  parameter int WFRAC       = 14,
  parameter int MU_SHIFT    = 6,
  parameter int ITER_CYCLES = 175
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_ref,
  input  logic signed [DW-1:0] in_desired,
  output logic signed [DW-1:0] err_out,
  output logic                 ready,
  output logic [3:0]           dbg_state,
  output logic [3:0]           dbg_mul_in,
  output logic [3:0]           dbg_mul_out,
  output logic [3:0]           dbg_add_in
);

  localparam int IW   = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam int CW   = $clog2(ITER_CYCLES + 1);
  localparam int PW   = WW + DW;
  localparam int ACCW = PW + IW;

  localparam logic signed [ACCW-1:0] E_MAX = ACCW'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] E_MIN = ACCW'(-(2 ** (DW - 1)));
  localparam logic signed [ACCW-1:0] W_MAX = ACCW'((2 ** (WW - 1)) - 1);
  localparam logic signed [ACCW-1:0] W_MIN = ACCW'(-(2 ** (WW - 1)));

  function automatic logic signed [DW-1:0] clip_err(input logic signed [ACCW-1:0] v);
    if (v > E_MAX)      return E_MAX[DW-1:0];
    else if (v < E_MIN) return E_MIN[DW-1:0];
    else                return v[DW-1:0];
  endfunction

  function automatic logic signed [WW-1:0] clip_coef(input logic signed [ACCW-1:0] v);
    if (v > W_MAX)      return W_MAX[WW-1:0];
    else if (v < W_MIN) return W_MIN[WW-1:0];
    else                return v[WW-1:0];
  endfunction

  logic                 rst_sync_n;
  lms_state_e           state;
  logic [IW-1:0]        idx;
  logic                 push;
  logic signed [DW-1:0] x_rd;
  logic signed [WW-1:0] w_rd;

  logic signed [WW-1:0]   op_a;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   prod_step;
  logic signed [ACCW-1:0] y_est;
  logic signed [ACCW-1:0] add_a;
  logic signed [ACCW-1:0] add_b;
  logic signed [ACCW-1:0] sum;

  logic signed [ACCW-1:0] acc_q, acc_d;
  logic signed [DW-1:0]   des_q, des_d;
  logic signed [DW-1:0]   err_q, err_d;
  logic                   rdy_q, rdy_d;
  logic                   coef_wr;
  logic signed [WW-1:0]   coef_new;

  lms_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lms_ctrl #(
    .N           (NTAPS),
    .ITER_CYCLES (ITER_CYCLES),
    .IW          (IW),
    .CW          (CW)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (in_valid),
    .state (state),
    .idx   (idx),
    .push  (push)
  );

  lms_sample_stack #(
    .DW (DW),
    .N  (NTAPS),
    .IW (IW)
  ) u_samples (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push    (push),
    .din     (in_ref),
    .rd_idx  (idx),
    .rd_data (x_rd)
  );

  lms_weight_stack #(
    .WW (WW),
    .N  (NTAPS),
    .IW (IW)
  ) u_coefs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (coef_wr),
    .idx     (idx),
    .wr_data (coef_new),
    .rd_data (w_rd)
  );

  // Shared multiplier: coefficient times sample while filtering,
  // error times sample while adapting.
  always_comb begin
    if (state == ST_MAC) op_a = w_rd;
    else                 op_a = {{(WW - DW){err_q[DW-1]}}, err_q};
    prod      = op_a * x_rd;
    prod_step = prod >>> MU_SHIFT;
    y_est     = acc_q >>> WFRAC;
  end

  // Shared adder operand selection.
  always_comb begin
    unique case (state)
      ST_MAC: begin
        add_a = acc_q;
        add_b = ACCW'(prod);
      end
      ST_ERR: begin
        add_a = ACCW'(des_q);
        add_b = -y_est;
      end
      ST_UPD: begin
        add_a = ACCW'(w_rd);
        add_b = ACCW'(prod_step);
      end
      default: begin
        add_a = '0;
        add_b = '0;
      end
    endcase
    sum = add_a + add_b;
  end

  always_comb begin
    acc_d    = acc_q;
    des_d    = des_q;
    err_d    = err_q;
    rdy_d    = 1'b0;
    coef_wr  = (state == ST_UPD);
    coef_new = clip_coef(sum);
    if (push) begin
      acc_d = '0;
      des_d = in_desired;
    end
    if (state == ST_MAC) acc_d = sum;
    if (state == ST_ERR) begin
      err_d = clip_err(sum);
      rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      des_q <= '0;
      err_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      des_q <= des_d;
      err_q <= err_d;
      rdy_q <= rdy_d;
    end
  end

  assign err_out     = err_q;
  assign ready       = rdy_q;
  assign dbg_state   = state;
  assign dbg_mul_in  = x_rd[3:0];
  assign dbg_mul_out = prod[3:0];
  assign dbg_add_in  = add_b[3:0];

endmodule

// File: rtl/lms_canceller_chk.sv
module lms_canceller_chk
  import lms_pkg::*;
#(
  parameter int DW          = 8,
  parameter int ITER_CYCLES = 175
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 ready,
  input logic [3:0]           dbg_state,
  input logic signed [DW-1:0] err_out
);

  localparam int CW = $clog2(ITER_CYCLES + 1);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  busy_cnt <= '0;
    else if (dbg_state == ST_IDLE) busy_cnt <= '0;
    else                         busy_cnt <= busy_cnt + 1'b1;
  end

  // R2: acceptance from idle goes straight to accumulation
  a_r2_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == ST_IDLE && in_valid) |=> (dbg_state == ST_MAC));

  // R3: a request during padding does not restart the sequence
  a_r3_busy_ignores_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == ST_HOLD && in_valid) |=> (dbg_state == ST_HOLD || dbg_state == ST_IDLE));

  // R4: each iteration occupies exactly ITER_CYCLES cycles
  a_r4_fixed_length: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == ST_IDLE && busy_cnt != '0) |-> (busy_cnt == CW'(ITER_CYCLES - 1)));

  // R6: ready lasts one cycle
  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R6: the output only moves with a ready strobe
  a_r6_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(err_out));

  // R8: ready is raised only in the update phase
  a_r8_ready_in_update: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (dbg_state == ST_UPD));

  // R8: only defined state codes appear
  a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state <= 4'd4);

endmodule

bind lms_canceller lms_canceller_chk #(
  .DW          (DW),
  .ITER_CYCLES (ITER_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .ready     (ready),
  .dbg_state (dbg_state),
  .err_out   (err_out)
);

// File: tb/sim_lms_canceller.sv
`timescale 1ns/1ps
module sim_lms_canceller;

  localparam int N     = 8;
  localparam int WFRAC = 14;
  localparam int MU    = 6;
  localparam int ITER  = 175;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [7:0] in_ref;
  logic signed [7:0] in_desired;
  logic signed [7:0] err_out;
  logic              ready;
  logic [3:0]        dbg_state;
  logic [3:0]        dbg_mul_in;
  logic [3:0]        dbg_mul_out;
  logic [3:0]        dbg_add_in;

  int cyc   = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int t_acc = 0;
  int wm [N];
  int xm [N];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lms_canceller u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ref      (in_ref),
    .in_desired  (in_desired),
    .err_out     (err_out),
    .ready       (ready),
    .dbg_state   (dbg_state),
    .dbg_mul_in  (dbg_mul_in),
    .dbg_mul_out (dbg_mul_out),
    .dbg_add_in  (dbg_add_in)
  );

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int sat(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic model_clear;
    for (int k = 0; k < N; k++) begin
      wm[k] = 0;
      xm[k] = 0;
    end
  endtask

  // Bit-accurate model of one iteration, written from R2, R5, R7, R11.
  task automatic model_step(input int x, input int d, output int e, output int raw);
    int acc;
    int y;
    for (int k = N - 1; k > 0; k--) xm[k] = xm[k-1];
    xm[0] = x;
    acc = 0;
    for (int k = 0; k < N; k++) acc += wm[k] * xm[k];
    y   = acc >>> WFRAC;
    raw = d - y;
    e   = sat(raw, -128, 127);
    for (int k = 0; k < N; k++) wm[k] = sat(wm[k] + ((e * xm[k]) >>> MU), -32768, 32767);
  endtask

  task automatic do_reset;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  // Ends at the negedge after the accepting edge.
  task automatic start_iter(input int x, input int d);
    while (dbg_state != 4'd0) @(negedge clk);
    in_valid   = 1'b1;
    in_ref     = 8'(x);
    in_desired = 8'(d);
    @(posedge clk);
    @(negedge clk);
    t_acc    = cyc;
    in_valid = 1'b0;
  endtask

  task automatic finish_iter(input int e_exp, input string tag);
    while (!ready) @(negedge clk);
    chk("R6 ready latency", cyc - t_acc, N + 1);
    chk("R8 state at ready", int'(dbg_state), 3);
    chk(tag, int'(err_out), e_exp);
    @(negedge clk);
    chk("R6 ready width", int'(ready), 0);
  endtask

  task automatic run_iter(input int x, input int d, input string tag, output int e);
    int raw;
    start_iter(x, d);
    model_step(x, d, e, raw);
    finish_iter(e, tag);
  endtask

  task automatic t_reset_state;
    int e;
    int raw;
    int w0;
    do_reset();
    chk("R1 err after reset", int'(err_out), 0);
    chk("R1 ready after reset", int'(ready), 0);
    chk("R1 state after reset", int'(dbg_state), 0);
    // reset in the middle of an iteration
    start_iter(55, -90);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 state during reset", int'(dbg_state), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
    chk("R1 err after mid reset", int'(err_out), 0);
    // zero coefficients: error equals desired; debug taps after acceptance
    start_iter(37, -50);
    chk("R8 state after accept", int'(dbg_state), 1);
    chk("R9 mul_in nibble", int'(dbg_mul_in), 37 & 15);
    chk("R9 mul_out nibble", int'(dbg_mul_out), 0);
    chk("R9 add_in nibble", int'(dbg_add_in), 0);
    model_step(37, -50, e, raw);
    finish_iter(e, "R5 first result");
    chk("R1 first result equals desired", int'(err_out), -50);
    repeat (N - 1) @(negedge clk);
    chk("R8 state in padding", int'(dbg_state), 4);
    // nonzero tap-0 coefficient on the debug taps
    w0 = wm[0];
    start_iter(20, 10);
    chk("R9 mul_in nibble", int'(dbg_mul_in), 20 & 15);
    chk("R9 mul_out nibble", int'(dbg_mul_out), (w0 * 20) & 15);
    chk("R9 add_in nibble", int'(dbg_add_in), (w0 * 20) & 15);
    model_step(20, 10, e, raw);
    finish_iter(e, "R7 second result");
  endtask

  task automatic t_basic;
    int e;
    for (int k = 0; k < 10; k++) begin
      run_iter(((k * 53 + 17) % 256) - 128, ((k * 91 + 5) % 256) - 128,
               "R2 R5 R7 error", e);
    end
  endtask

  task automatic t_ignore;
    int e;
    int raw;
    start_iter(60, 40);
    model_step(60, 40, e, raw);
    in_valid   = 1'b1;
    in_ref     = -8'sd100;
    in_desired = 8'sd99;
    @(negedge clk);
    in_valid = 1'b0;
    finish_iter(e, "R3 result with request during accumulate");
    repeat (10) @(negedge clk);
    in_valid   = 1'b1;
    in_ref     = 8'sd77;
    in_desired = -8'sd77;
    repeat (3) @(negedge clk);
    chk("R3 still padding", int'(dbg_state), 4);
    in_valid = 1'b0;
    run_iter(-33, 70, "R3 later result unaffected", e);
    run_iter(12, -5, "R3 later result unaffected", e);
  endtask

  task automatic t_spacing;
    int e;
    int raw;
    int r1;
    while (dbg_state != 4'd0) @(negedge clk);
    in_valid   = 1'b1;
    in_ref     = 8'sd25;
    in_desired = -8'sd60;
    @(negedge clk);
    model_step(25, -60, e, raw);
    while (!ready) @(negedge clk);
    r1 = cyc;
    chk("R4 first held result", int'(err_out), e);
    @(negedge clk);
    model_step(25, -60, e, raw);
    while (!ready) @(negedge clk);
    chk("R4 second held result", int'(err_out), e);
    chk("R4 ready spacing", cyc - r1, ITER);
    in_valid = 1'b0;
    run_iter(-7, 3, "R4 after held valid", e);
  endtask

  task automatic t_saturate;
    int e;
    int raw;
    for (int k = 0; k < 30; k++) run_iter(100, 120, "R5 training", e);
    start_iter(100, -128);
    model_step(100, -128, e, raw);
    chk("R11 unclipped below range", int'(raw < -128), 1);
    finish_iter(e, "R11 model match");
    chk("R11 negative clip", int'(err_out), -128);
    for (int k = 0; k < 8; k++) run_iter(-100, -120, "R5 retrain", e);
    start_iter(-100, 127);
    model_step(-100, 127, e, raw);
    chk("R11 unclipped above range", int'(raw > 127), 1);
    finish_iter(e, "R11 model match");
    chk("R11 positive clip", int'(err_out), 127);
  endtask

  task automatic t_converge;
    int e;
    int lf;
    int x;
    int prev;
    int first_sum;
    int last_sum;
    do_reset();
    lf        = 16'hACE1;
    prev      = 0;
    first_sum = 0;
    last_sum  = 0;
    for (int k = 0; k < 300; k++) begin
      lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 16'hFFFF;
      x  = lf & 255;
      if (x > 127) x -= 256;
      run_iter(x, prev >>> 1, "R10 tracking error", e);
      if (k < 16)   first_sum += (e < 0) ? -e : e;
      if (k >= 284) last_sum  += (e < 0) ? -e : e;
      prev = x;
    end
    chk("R10 error shrinks", int'(last_sum * 4 < first_sum), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
    summary();
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_ref     = '0;
    in_desired = '0;
    model_clear();
    t_reset_state();
    t_basic();
    t_ignore();
    t_spacing();
    t_saturate();
    t_converge();
    summary();
    $finish;
  end

endmodule